// File: doc/BRIEF.md
# Cipher Unit Start-Up and Block Sequencer

This block is the control sequencer that sits between the register file of a block-cipher unit and its round datapath. Out of reset it first asks a random-number source to reseed and waits for the acknowledge. It then overwrites every key-share, IV, input-data and output-data word with random data, one word per cycle. Only after that does it report idle and ready for input. As a result, all STATUS bits leave reset at zero.

After start-up it follows which of the input-data words software has written. In automatic mode it launches a block once every word has been written at least once, in any order. In manual mode it launches only on an explicit trigger. It also follows which output-data words have been read. In automatic mode it holds a finished result back, raising STALL, rather than overwrite output that has not been fully read. In manual mode it overwrites the output and records the loss instead.

The register file uses the clear-select outputs to steer the random words. The datapath uses the start pulse and returns a done pulse. The register file uses the latch pulse to capture a result into the output words.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: While reset is held and right after it is released, `status` is 0 (bit 0 idle, bit 1 stall, bit 2 output lost, bit 3 output valid, bit 4 input ready). `reseed_req` is 1 from release and stays 1 until `reseed_ack` is seen.
- R2: The cycle after the acknowledge, `clr_we` goes high for exactly CLR_WORDS (2*N_KEY+N_IV+2*N_DATA, 28 by default) consecutive cycles. During these cycles `clr_sel` counts 0,1,2,… upward, and `clr_word` equals `rnd_word` in the same cycle. After the last word, `status` reads idle=1 and input-ready=1.
- R3: The idle bit is 0 during reseed, clearing, a running block and a stall. It is 1 only when no such activity is pending.
- R4: `cfg_we_ok` follows `cfg_we` only while the idle bit is 1. Otherwise it is 0, so key and IV writes are dropped.
- R5: In automatic mode (`manual_mode`=0), `dp_start` pulses for one cycle, in the cycle after the write that completes the set of written words. The words may arrive in any order, and there is no pulse while any word is still unwritten.
- R6: A data-word write clears input-ready. Starting a block sets it again. A write in the same cycle as `dp_start` counts toward the next block and leaves input-ready at 0.
- R7: Data-word writes made before the clearing phase ends are ignored. They count toward no block.
- R8: In automatic mode, a done pulse that arrives while output is valid and not all words have been read sets stall=1 (with idle=0). The stall ends, and `out_latch` pulses, in the cycle in which the last unread word is read. If the last read falls in the same cycle as the done pulse, no stall occurs.
- R9: `out_latch` sets output-valid. Reading all output words at least once clears output-valid.
- R10: In manual mode only `start_trigger` (while idle) starts a block. A result never stalls. Latching over a valid, not fully read output sets output-lost, which then stays 1 until reset.
- R11: A `dp_done` pulse while no block is running has no effect on `status` or `out_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| manual_mode | input | 1 | 1 = blocks start only on trigger |
| cfg_we | input | 1 | Key-share / IV write strobe from the register file |
| cfg_we_ok | output | 1 | Gated key/IV write enable |
| din_we | input | N_DATA | Per-word input-data write strobes |
| dout_re | input | N_DATA | Per-word output-data read strobes |
| start_trigger | input | 1 | Manual-mode start request |
| reseed_req | output | 1 | Reseed request to the random source |
| reseed_ack | input | 1 | Reseed acknowledge |
| rnd_word | input | WORD_W | Random word for clearing |
| clr_we | output | 1 | Clearing write enable |
| clr_sel | output | SEL_W | Index of the word being cleared |
| clr_word | output | WORD_W | Random data to write |
| dp_start | output | 1 | Start pulse to the datapath (input is loaded) |
| dp_done | input | 1 | Datapath finished pulse |
| out_latch | output | 1 | Capture result into output words |
| status | output | 5 | {ready, valid, lost, stall, idle} |

## Verification
Two pairs of events can fall in the same cycle. In the first, a data-word write coincides with the start pulse. The bench writes word 0 in the very cycle `dp_start` is high. It then judges that input-ready stays 0, and that three further writes are enough to launch the next block. In the second, the final output read coincides with the datapath done pulse. The bench reads three words while the block runs and reads the fourth together with `dp_done`. It then requires `out_latch` in that cycle and no stall afterwards, while a separate scenario shows that a done pulse with words still unread does stall.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   typedef enum logic [2:0] {
      SQ_RESEED,
      SQ_CLEAR,
      SQ_IDLE,
      SQ_BUSY,
      SQ_STALL
   } sq_state_e;

   localparam int ST_IDLE  = 0;
   localparam int ST_STALL = 1;
   localparam int ST_LOST  = 2;
   localparam int ST_VALID = 3;
   localparam int ST_READY = 4;
   localparam int ST_W     = 5;

endpackage

// File: rtl/cseq_mask.sv
// Per-word "touched" tracker. SET_WINS picks the priority between a clear
// and a new set in the same cycle.
module cseq_mask #(
   parameter int N        = 4,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] mask,
   output logic         full_now
);

   logic [N-1:0] mask_nx;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb mask_nx = clr ? set : (mask | set);
      end else begin : g_clr_wins
         always_comb mask_nx = clr ? '0 : (mask | set);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask <= '0;
      else        mask <= mask_nx;
   end

   assign full_now = &(mask | set);

endmodule

// File: rtl/cseq_clear.sv
// Random-wipe walker: one word per cycle while run is high.
module cseq_clear #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 28,
   localparam int SEL_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [WORD_W-1:0] rnd_in,
   output logic              we,
   output logic [SEL_W-1:0]  sel,
   output logic [WORD_W-1:0] word,
   output logic              last
);

   localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(WORDS - 1);

   logic [SEL_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (run) cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
   end

   assign we   = run;
   assign sel  = cnt;
   assign word = rnd_in;
   assign last = run && (cnt == LAST_IDX);

   AST_CLEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel != LAST_IDX) |=> (we && sel == $past(sel) + 1'b1)); // R2

endmodule

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl
   import cseq_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int N_DATA = 4,
   parameter int N_KEY  = 8,
   parameter int N_IV   = 4,
   localparam int CLR_WORDS = 2*N_KEY + N_IV + 2*N_DATA,
   localparam int SEL_W     = $clog2(CLR_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              manual_mode,
   input  logic              cfg_we,
   output logic              cfg_we_ok,
   input  logic [N_DATA-1:0] din_we,
   input  logic [N_DATA-1:0] dout_re,
   input  logic              start_trigger,
   output logic              reseed_req,
   input  logic              reseed_ack,
   input  logic [WORD_W-1:0] rnd_word,
   output logic              clr_we,
   output logic [SEL_W-1:0]  clr_sel,
   output logic [WORD_W-1:0] clr_word,
   output logic              dp_start,
   input  logic              dp_done,
   output logic              out_latch,
   output logic [ST_W-1:0]   status
);

   generate
      if (WORD_W < 1)                 begin : g_bad_w  $error("WORD_W must be positive"); end
      if (N_DATA < 1 || N_DATA > 32)  begin : g_bad_d  $error("N_DATA out of range"); end
      if (N_KEY < 1 || N_IV < 0)      begin : g_bad_k  $error("key/IV word counts invalid"); end
   endgenerate

   sq_state_e state, state_nx;

   logic              clr_last;
   logic [N_DATA-1:0] din_acc;
   logic [N_DATA-1:0] wr_mask, rd_mask;
   logic              wr_full_unused, rd_full_now;
   logic              go, done_busy, unread, stall_go;
   logic              out_valid, out_lost, in_ready;

   // ---------------- random wipe ----------------
   cseq_clear #(.WORD_W(WORD_W), .WORDS(CLR_WORDS)) u_clear (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (state == SQ_CLEAR),
      .rnd_in (rnd_word),
      .we     (clr_we),
      .sel    (clr_sel),
      .word   (clr_word),
      .last   (clr_last)
   );

   // ---------------- word trackers ----------------
   assign din_acc = (state == SQ_RESEED || state == SQ_CLEAR) ? '0 : din_we;

   cseq_mask #(.N(N_DATA), .SET_WINS(1'b1)) u_wr_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (din_acc),
      .clr      (go),
      .mask     (wr_mask),
      .full_now (wr_full_unused)
   );

   cseq_mask #(.N(N_DATA), .SET_WINS(1'b0)) u_rd_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (dout_re),
      .clr      (out_latch),
      .mask     (rd_mask),
      .full_now (rd_full_now)
   );

   // ---------------- sequencing ----------------
   assign go        = (state == SQ_IDLE) && (manual_mode ? start_trigger : (&wr_mask));
   assign done_busy = (state == SQ_BUSY) && dp_done;
   assign unread    = out_valid && !rd_full_now;
   assign stall_go  = done_busy && !manual_mode && unread;
   assign out_latch = (done_busy && !stall_go) || ((state == SQ_STALL) && rd_full_now);

   always_comb begin
      state_nx = state;
      unique case (state)
         SQ_RESEED: if (reseed_ack)  state_nx = SQ_CLEAR;
         SQ_CLEAR:  if (clr_last)    state_nx = SQ_IDLE;
         SQ_IDLE:   if (go)          state_nx = SQ_BUSY;
         SQ_BUSY:   if (dp_done)     state_nx = stall_go ? SQ_STALL : SQ_IDLE;
         SQ_STALL:  if (rd_full_now) state_nx = SQ_IDLE;
         default:                    state_nx = SQ_RESEED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_RESEED;
         out_valid <= 1'b0;
         out_lost  <= 1'b0;
         in_ready  <= 1'b0;
      end else begin
         state <= state_nx;

         if (out_latch)                     out_valid <= 1'b1;
         else if (out_valid && rd_full_now) out_valid <= 1'b0;

         if (done_busy && manual_mode && unread) out_lost <= 1'b1;

         if (clr_last)      in_ready <= 1'b1;
         else if (|din_acc) in_ready <= 1'b0;
         else if (go)       in_ready <= 1'b1;
      end
   end

   assign reseed_req = (state == SQ_RESEED);
   assign dp_start   = go;
   assign cfg_we_ok  = cfg_we && (state == SQ_IDLE);

   always_comb begin
      status           = '0;
      status[ST_IDLE]  = (state == SQ_IDLE);
      status[ST_STALL] = (state == SQ_STALL);
      status[ST_LOST]  = out_lost;
      status[ST_VALID] = out_valid;
      status[ST_READY] = in_ready;
   end

   // ---------------- assertions ----------------
   AST_INIT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (reseed_req || clr_we) |-> (!status[ST_IDLE] && !status[ST_READY])); // R3

   AST_START_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      dp_start |=> !status[ST_IDLE]); // R3

   AST_READY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (dp_start && din_we == '0) |=> status[ST_READY]); // R6

   AST_STALL_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_STALL] |-> status[ST_VALID]); // R8

   AST_LATCH_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_latch |=> status[ST_VALID]); // R9

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status[ST_LOST] |=> status[ST_LOST]); // R10

endmodule

// File: tb/tb_cipher_seq_ctrl.sv
module tb_cipher_seq_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int CLRN = 28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        manual_mode = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_we_ok;
   logic [3:0]  din_we = '0;
   logic [3:0]  dout_re = '0;
   logic        start_trigger = 1'b0;
   logic        reseed_req;
   logic        reseed_ack = 1'b0;
   logic [31:0] rnd_word = '0;
   logic        clr_we;
   logic [4:0]  clr_sel;
   logic [31:0] clr_word;
   logic        dp_start;
   logic        dp_done = 1'b0;
   logic        out_latch;
   logic [4:0]  status;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cipher_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .manual_mode(manual_mode),
      .cfg_we(cfg_we), .cfg_we_ok(cfg_we_ok),
      .din_we(din_we), .dout_re(dout_re), .start_trigger(start_trigger),
      .reseed_req(reseed_req), .reseed_ack(reseed_ack), .rnd_word(rnd_word),
      .clr_we(clr_we), .clr_sel(clr_sel), .clr_word(clr_word),
      .dp_start(dp_start), .dp_done(dp_done), .out_latch(out_latch),
      .status(status)
   );

   // status bits: 0 idle, 1 stall, 2 lost, 3 valid, 4 ready
   function automatic logic [4:0] st(bit rdy, bit vld, bit lst, bit stl, bit idl);
      return {rdy, vld, lst, stl, idl};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_word(logic [3:0] m);
      din_we = m; tick(); din_we = '0;
   endtask

   task automatic read_word(logic [3:0] m);
      dout_re = m; tick(); dout_re = '0;
   endtask

   task automatic t_reset_and_early_writes();
      rst_n = 1'b0; tick(2);
      check("R1 status in reset", status, 0);
      rst_n = 1'b1; tick();
      check("R1 status after release", status, 0);
      check("R1 reseed_req", reseed_req, 1);
      din_we = 4'hF; tick(); din_we = '0;  // R7 stimulus during reseed
      tick(2);
      check("R1 reseed_req held", reseed_req, 1);
      check("R3 idle low in reseed", status[0], 0);
   endtask

   task automatic t_clear();
      reseed_ack = 1'b1; tick(); reseed_ack = 1'b0;
      for (int i = 0; i < CLRN; i++) begin
         rnd_word = 32'hA5000000 + i * 32'h1357;
         #1;
         check("R2 clr_we", clr_we, 1);
         check("R2 clr_sel", clr_sel, i);
         check("R2 clr_word", clr_word, 32'hA5000000 + i * 32'h1357);
         if (i == 3) check("R3 idle low in clear", status[0], 0);
         tick();
      end
      check("R2 clr_we off", clr_we, 0);
      check("R2 idle+ready", status, st(1,0,0,0,1));
      check("R1 reseed_req dropped", reseed_req, 0);
   endtask

   task automatic t_ignored_early();
      tick(3);
      check("R7 no start from early writes", dp_start, 0);
      check("R7 still idle", status, st(1,0,0,0,1));
      cfg_we = 1'b1; #1;
      check("R4 cfg pass when idle", cfg_we_ok, 1);
      cfg_we = 1'b0;
   endtask

   task automatic t_auto_first();
      write_word(4'b0100);
      check("R6 ready falls on write", status[4], 0);
      write_word(4'b0001);
      write_word(4'b1000);
      check("R5 no start with 3 words", dp_start, 0);
      write_word(4'b0010);
      check("R5 start after 4th word", dp_start, 1);
      tick();
      check("R5 start is one pulse", dp_start, 0);
      check("R3/R6 busy, ready", status, st(1,0,0,0,0));
      cfg_we = 1'b1; #1;
      check("R4 cfg dropped when busy", cfg_we_ok, 0);
      cfg_we = 1'b0;
      dp_done = 1'b1; #1;
      check("R9 latch on done", out_latch, 1);
      tick(); dp_done = 1'b0;
      check("R9 valid set", status, st(1,1,0,0,1));
   endtask

   task automatic t_collide_write_and_stall();
      write_word(4'b0010);
      write_word(4'b0100);
      write_word(4'b1000);
      write_word(4'b0001);
      check("R5 start", dp_start, 1);
      din_we = 4'b0001; tick(); din_we = '0;   // write in start cycle
      check("R6 write at start keeps ready low", status[4], 0);
      dp_done = 1'b1; #1;
      check("R8 no latch over unread", out_latch, 0);
      tick(); dp_done = 1'b0;
      check("R8 stall", status, st(0,1,0,1,0));
      read_word(4'b0001);
      read_word(4'b0010);
      read_word(4'b0100);
      check("R8 still stalled", status[1], 1);
      dout_re = 4'b1000; #1;
      check("R8 latch on last read", out_latch, 1);
      tick(); dout_re = '0;
      check("R8 stall released", status, st(0,1,0,0,1));
      write_word(4'b0010);
      write_word(4'b0100);
      check("R6 no start yet", dp_start, 0);
      write_word(4'b1000);
      check("R6 word0 from start cycle counted", dp_start, 1);
      tick();
   endtask

   task automatic t_collide_read_and_done();
      read_word(4'b0001);
      read_word(4'b0010);
      read_word(4'b0100);
      dout_re = 4'b1000; dp_done = 1'b1; #1;
      check("R8 latch when last read meets done", out_latch, 1);
      tick(); dout_re = '0; dp_done = 1'b0;
      check("R8 no stall", status, st(1,1,0,0,1));
      read_word(4'b1111);
      check("R9 valid cleared after reads", status[3], 0);
      dp_done = 1'b1; #1;
      check("R11 no latch when idle", out_latch, 0);
      tick(); dp_done = 1'b0;
      check("R11 status unchanged", status, st(1,0,0,0,1));
   endtask

   task automatic t_manual();
      manual_mode = 1'b1;
      write_word(4'b1111);
      tick(2);
      check("R10 no auto start in manual", dp_start, 0);
      check("R6 ready low before load", status[4], 0);
      start_trigger = 1'b1; #1;
      check("R10 trigger starts", dp_start, 1);
      tick(); start_trigger = 1'b0;
      dp_done = 1'b1; tick(); dp_done = 1'b0;
      check("R10 first result valid", status, st(1,1,0,0,1));
      start_trigger = 1'b1; tick(); start_trigger = 1'b0;
      dp_done = 1'b1; #1;
      check("R10 latch without stall", out_latch, 1);
      tick(); dp_done = 1'b0;
      check("R10 lost set", status, st(1,1,1,0,1));
      read_word(4'b1111);
      tick(3);
      check("R10 lost sticky", status[2], 1);
      manual_mode = 1'b0;
   endtask

   initial begin
      t_reset_and_early_writes();
      t_clear();
      t_ignored_early();
      t_auto_first();
      t_collide_write_and_stall();
      t_collide_read_and_done();
      t_manual();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule